// File: doc/BRIEF.md
# Conductance Program-and-Verify Sequencer

This block moves a resistive memory cell to a requested conductance. It does this by repeating two steps: a programming pulse under a compliance-current limit, then a read-back of the result. After each read it compares the value with the target. If the value is low, it raises the compliance setting by a step proportional to the remaining error. If the value is inside the acceptance window, it stops. If the value ends up too high, it erases the cell with a reset operation and starts the climb again from the initial compliance setting.

A higher-level calibration engine starts the block with a target between 100 and 400 µS. The engine then waits for a single-cycle completion pulse that carries a pass/fail flag and the number of iterations spent in the final attempt. The analog drivers and the measurement path sit outside the block. Each of them answers a strobe with a one-cycle acknowledge: `dev_done` for program and reset operations, and `meas_valid` together with `meas` for reads. Conductances and the compliance setting are unsigned integers, one LSB per µS.

Top module: `pv_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is 0, the block holds `prog_stb`, `read_stb`, `rst_stb` and `done` at 0. After reset, `pass` and `iters` are also 0.
- R2: `start` is taken only when idle, and the value of `target` is captured at that moment. A `start` pulse or a change on `target` while `busy` is 1 has no effect on the run in progress.
- R3: Each iteration runs in a fixed order: a one-cycle `prog_stb` with the compliance value on `cc_set`, a wait for `dev_done`, a one-cycle `read_stb`, and a wait for `meas_valid`. At most one strobe is high in any cycle.
- R4: A run ends with `pass`=1 when |target − meas| ≤ TOL (default 5). `iters` then reports the number of program steps since the last restart.
- R5: When meas < target − TOL, `cc_set` increases by (target − meas) >> 1 in iterations 1 to SWITCH_ITER (default 10) of an attempt, and by (target − meas) >> 2 in later iterations. The step is at least 1, and `cc_set` saturates at 1023. Within an attempt, `cc_set` strictly rises unless it is saturated.
- R6: When meas is still low at the end of iteration MAX_ITER (default 20), the run ends with `pass`=0 and `iters`=MAX_ITER. No attempt issues more than MAX_ITER program strobes.
- R7: When meas > target + TOL, the block issues `rst_stb` and waits for `dev_done`. It then returns `cc_set` to INIT_CC (default 50), clears the iteration count and programs again. The first program strobe of every run also uses INIT_CC.
- R8: When meas overshoots after MAX_RESTART (default 3) restarts have already been made, the run ends with `pass`=0 and no further reset. `iters` then holds the iteration count of that last attempt.
- R9: `done` is a one-cycle pulse and the block is idle in the following cycle. `pass` and `iters` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (taken when idle) |
| target | input | 10 | Requested conductance, µS |
| dev_done | input | 1 | One-cycle acknowledge of a program or reset operation |
| meas_valid | input | 1 | One-cycle flag, `meas` holds a read result |
| meas | input | 10 | Measured conductance, µS |
| cc_set | output | 10 | Compliance-current setting for the program operation |
| prog_stb | output | 1 | Program request |
| read_stb | output | 1 | Read request |
| rst_stb | output | 1 | Reset (erase) request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished (one cycle) |
| pass | output | 1 | Last run reached the acceptance window |
| iters | output | 5 | Iterations used in the final attempt of the last run |

## Verification
The assertions assume that the device side never sends `dev_done` or `meas_valid` unless one of its operations is outstanding, and that it answers each strobe exactly once. The bench's behavioural cell model meets this by construction: it acknowledges only after it sees a strobe, with a fixed latency. The model lets the cell's conductance only grow under programming and clears it on reset. Its gain drops after each reset, so overshoot, restart-then-success, restart exhaustion and iteration-cap exhaustion all come from ordinary target and gain choices. Targets stay inside 100 to 400 µS in both the directed and the random runs.

// File: rtl/pv_pkg.sv
package pv_pkg;

    localparam int PV_VAL_W = 10;
    localparam int PV_CC_W  = 10;

    typedef logic [PV_VAL_W-1:0]      pv_val_t;
    typedef logic [PV_CC_W-1:0]       pv_cc_t;
    typedef logic signed [PV_VAL_W:0] pv_err_t;

    typedef enum logic [1:0] {
        CMP_IN_BAND = 2'd0,
        CMP_UNDER   = 2'd1,
        CMP_OVER    = 2'd2
    } pv_cmp_e;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_PROG  = 4'd1,
        S_PWAIT = 4'd2,
        S_READ  = 4'd3,
        S_RWAIT = 4'd4,
        S_EVAL  = 4'd5,
        S_RST   = 4'd6,
        S_XWAIT = 4'd7,
        S_DONE  = 4'd8
    } pv_state_e;

    typedef struct packed {
        pv_cmp_e cls;
        pv_err_t err;
    } pv_eval_t;

    // Proportional step for a positive error; fine selects the quarter scale.
    // A shifted result of zero still moves the setting by one.
    function automatic pv_cc_t pv_scaled_step(input pv_err_t err, input logic fine);
        pv_err_t sh;
        sh = fine ? (err >>> 2) : (err >>> 1);
        if (sh <= 0)
            return pv_cc_t'(1);
        return sh[PV_CC_W-1:0];
    endfunction

endpackage

// File: rtl/pv_compare.sv
module pv_compare
    import pv_pkg::*;
#(
    parameter int TOL = 5
) (
    input  pv_val_t  tgt,
    input  pv_val_t  meas,
    output pv_eval_t res
);
    localparam pv_err_t TOL_HI = pv_err_t'(TOL);
    localparam pv_err_t TOL_LO = -pv_err_t'(TOL);

    pv_err_t diff;

    always_comb begin
        diff    = $signed({1'b0, tgt}) - $signed({1'b0, meas});
        res.err = diff;
        if (diff > TOL_HI)
            res.cls = CMP_UNDER;
        else if (diff < TOL_LO)
            res.cls = CMP_OVER;
        else
            res.cls = CMP_IN_BAND;
    end
endmodule

// File: rtl/pv_step.sv
module pv_step
    import pv_pkg::*;
#(
    parameter int SWITCH_ITER = 10,
    parameter int ITER_W      = 5
) (
    input  pv_err_t           err,
    input  logic [ITER_W-1:0] iter,
    output pv_cc_t            step
);
    logic fine;

    always_comb begin
        fine = (iter >= ITER_W'(SWITCH_ITER));
        step = pv_scaled_step(err, fine);
    end
endmodule

// File: rtl/pv_cc_reg.sv
module pv_cc_reg
    import pv_pkg::*;
#(
    parameter int INIT_CC = 50
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load_init,
    input  logic   add_en,
    input  pv_cc_t step,
    output pv_cc_t cc
);
    localparam pv_cc_t CC_INIT = pv_cc_t'(INIT_CC);

    logic [PV_CC_W:0] sum;

    always_comb sum = {1'b0, cc} + {1'b0, step};

    always_ff @(posedge clk) begin
        if (rst)
            cc <= CC_INIT;
        else if (load_init)
            cc <= CC_INIT;
        else if (add_en)
            cc <= sum[PV_CC_W] ? '1 : sum[PV_CC_W-1:0];
    end
endmodule

// File: rtl/pv_seq.sv
module pv_seq
    import pv_pkg::*;
#(
    parameter int MAX_ITER    = 20,
    parameter int MAX_RESTART = 3,
    parameter int ITER_W      = 5,
    parameter int RST_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  pv_val_t           target,
    input  logic              dev_done,
    input  logic              meas_valid,
    input  pv_val_t           meas,
    input  pv_cmp_e           cls,
    output pv_val_t           tgt_q,
    output pv_val_t           meas_q,
    output logic [ITER_W-1:0] iter_q,
    output logic              cc_load_init,
    output logic              cc_add,
    output logic              prog_stb,
    output logic              read_stb,
    output logic              rst_stb,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ITER_W-1:0] iters
);
    pv_state_e         state;
    logic [RST_W-1:0]  rcnt_q;
    logic [ITER_W-1:0] iter_inc;
    logic              at_cap;
    logic              out_of_restarts;

    always_comb begin
        iter_inc        = iter_q + 1'b1;
        at_cap          = (iter_inc >= ITER_W'(MAX_ITER));
        out_of_restarts = (rcnt_q == RST_W'(MAX_RESTART));
        prog_stb        = (state == S_PROG);
        read_stb        = (state == S_READ);
        rst_stb         = (state == S_RST);
        busy            = (state != S_IDLE);
        done            = (state == S_DONE);
        cc_load_init    = ((state == S_IDLE) && start) ||
                          ((state == S_XWAIT) && dev_done);
        cc_add          = (state == S_EVAL) && (cls == CMP_UNDER) && !at_cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            tgt_q  <= '0;
            meas_q <= '0;
            iter_q <= '0;
            rcnt_q <= '0;
            pass   <= 1'b0;
            iters  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        tgt_q  <= target;
                        iter_q <= '0;
                        rcnt_q <= '0;
                        pass   <= 1'b0;
                        iters  <= '0;
                        state  <= S_PROG;
                    end
                end
                S_PROG:  state <= S_PWAIT;
                S_PWAIT: if (dev_done) state <= S_READ;
                S_READ:  state <= S_RWAIT;
                S_RWAIT: begin
                    if (meas_valid) begin
                        meas_q <= meas;
                        state  <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    unique case (cls)
                        CMP_IN_BAND: begin
                            pass  <= 1'b1;
                            iters <= iter_inc;
                            state <= S_DONE;
                        end
                        CMP_OVER: begin
                            if (out_of_restarts) begin
                                pass  <= 1'b0;
                                iters <= iter_inc;
                                state <= S_DONE;
                            end else begin
                                state <= S_RST;
                            end
                        end
                        default: begin
                            if (at_cap) begin
                                pass  <= 1'b0;
                                iters <= iter_inc;
                                state <= S_DONE;
                            end else begin
                                iter_q <= iter_inc;
                                state  <= S_PROG;
                            end
                        end
                    endcase
                end
                S_RST:   state <= S_XWAIT;
                S_XWAIT: begin
                    if (dev_done) begin
                        iter_q <= '0;
                        rcnt_q <= rcnt_q + 1'b1;
                        state  <= S_PROG;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pv_ctrl.sv
module pv_ctrl
    import pv_pkg::*;
#(
    parameter int TOL         = 5,
    parameter int MAX_ITER    = 20,
    parameter int SWITCH_ITER = 10,
    parameter int MAX_RESTART = 3,
    parameter int INIT_CC     = 50,
    localparam int ITER_W     = $clog2(MAX_ITER + 1),
    localparam int RST_W      = $clog2(MAX_RESTART + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [PV_VAL_W-1:0]     target,
    input  logic                    dev_done,
    input  logic                    meas_valid,
    input  logic [PV_VAL_W-1:0]     meas,
    output logic [PV_CC_W-1:0]      cc_set,
    output logic                    prog_stb,
    output logic                    read_stb,
    output logic                    rst_stb,
    output logic                    busy,
    output logic                    done,
    output logic                    pass,
    output logic [ITER_W-1:0]       iters
);
    pv_val_t           tgt_q;
    pv_val_t           meas_q;
    logic [ITER_W-1:0] iter_q;
    pv_eval_t          ev;
    pv_cc_t            step;
    logic              cc_load_init;
    logic              cc_add;

    pv_compare #(.TOL(TOL)) u_cmp (
        .tgt  (tgt_q),
        .meas (meas_q),
        .res  (ev)
    );

    pv_step #(.SWITCH_ITER(SWITCH_ITER), .ITER_W(ITER_W)) u_step (
        .err  (ev.err),
        .iter (iter_q),
        .step (step)
    );

    pv_cc_reg #(.INIT_CC(INIT_CC)) u_cc (
        .clk       (clk),
        .rst       (rst),
        .load_init (cc_load_init),
        .add_en    (cc_add),
        .step      (step),
        .cc        (cc_set)
    );

    pv_seq #(
        .MAX_ITER    (MAX_ITER),
        .MAX_RESTART (MAX_RESTART),
        .ITER_W      (ITER_W),
        .RST_W       (RST_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .target       (target),
        .dev_done     (dev_done),
        .meas_valid   (meas_valid),
        .meas         (meas),
        .cls          (ev.cls),
        .tgt_q        (tgt_q),
        .meas_q       (meas_q),
        .iter_q       (iter_q),
        .cc_load_init (cc_load_init),
        .cc_add       (cc_add),
        .prog_stb     (prog_stb),
        .read_stb     (read_stb),
        .rst_stb      (rst_stb),
        .busy         (busy),
        .done         (done),
        .pass         (pass),
        .iters        (iters)
    );
endmodule

// File: rtl/pv_ctrl_chk.sv
module pv_ctrl_chk #(
    parameter int MAX_ITER    = 20,
    parameter int MAX_RESTART = 3,
    parameter int INIT_CC     = 50,
    parameter int CC_W        = 10,
    parameter int ITER_W      = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [CC_W-1:0]   cc_set,
    input logic              prog_stb,
    input logic              read_stb,
    input logic              rst_stb,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [ITER_W-1:0] iters
);
    logic            fresh_q;
    logic [CC_W-1:0] last_cc_q;
    int unsigned     prog_cnt_q;
    int unsigned     rs_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q    <= 1'b1;
            last_cc_q  <= '0;
            prog_cnt_q <= 0;
            rs_cnt_q   <= 0;
        end else begin
            if (!busy || rst_stb)
                fresh_q <= 1'b1;
            else if (prog_stb)
                fresh_q <= 1'b0;
            if (prog_stb)
                last_cc_q <= cc_set;
            if (!busy || rst_stb)
                prog_cnt_q <= 0;
            else if (prog_stb)
                prog_cnt_q <= prog_cnt_q + 1;
            if (!busy)
                rs_cnt_q <= 0;
            else if (rst_stb)
                rs_cnt_q <= rs_cnt_q + 1;
        end
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(prog_stb || read_stb || rst_stb || done));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_stb, read_stb, rst_stb}));

    a_r3_prog_single_cycle: assert property (@(posedge clk) disable iff (rst)
        prog_stb |=> !prog_stb);

    a_r7_cc_from_init: assert property (@(posedge clk) disable iff (rst)
        (prog_stb && fresh_q) |-> (cc_set == CC_W'(INIT_CC)));

    a_r5_cc_rises: assert property (@(posedge clk) disable iff (rst)
        (prog_stb && !fresh_q) |-> ((cc_set > last_cc_q) || (&last_cc_q)));

    a_r6_iter_cap: assert property (@(posedge clk) disable iff (rst)
        prog_stb |-> (prog_cnt_q < MAX_ITER));

    a_r8_restart_cap: assert property (@(posedge clk) disable iff (rst)
        rst_stb |-> (rs_cnt_q < MAX_RESTART));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r4_pass_count: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |=> ((iters >= 1) && (iters <= ITER_W'(MAX_ITER))));
endmodule

bind pv_ctrl pv_ctrl_chk #(
    .MAX_ITER    (MAX_ITER),
    .MAX_RESTART (MAX_RESTART),
    .INIT_CC     (INIT_CC),
    .CC_W        (pv_pkg::PV_CC_W),
    .ITER_W      (ITER_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cc_set   (cc_set),
    .prog_stb (prog_stb),
    .read_stb (read_stb),
    .rst_stb  (rst_stb),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .iters    (iters)
);

// File: tb/sim_pv_ctrl.sv
module sim_pv_ctrl;
    localparam int LAT   = 3;
    localparam int INIT  = 50;
    localparam int TOLB  = 5;
    localparam int CAP   = 20;
    localparam int SWI   = 10;
    localparam int MAXR  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] target = '0;
    logic       dev_done = 1'b0;
    logic       meas_valid = 1'b0;
    logic [9:0] meas = '0;
    logic [9:0] cc_set;
    logic       prog_stb, read_stb, rst_stb, busy, done, pass;
    logic [4:0] iters;

    int tests = 0;
    int fails = 0;

    // behavioural cell and port monitor state
    int g_dev = 0, gain_dev = 4;
    int pend_p = 0, pend_r = 0, pend_x = 0;
    int n_prog = 0, n_rst = 0, n_done = 0, last_cc = 0;

    always #5 clk = ~clk;

    pv_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .target(target),
        .dev_done(dev_done), .meas_valid(meas_valid), .meas(meas),
        .cc_set(cc_set), .prog_stb(prog_stb), .read_stb(read_stb),
        .rst_stb(rst_stb), .busy(busy), .done(done), .pass(pass),
        .iters(iters)
    );

    function automatic int prog_result(int g, int cc, int gain);
        int v;
        v = (cc * gain) / 4;
        if (v > 1023) v = 1023;
        return (v > g) ? v : g;
    endfunction

    always @(negedge clk) begin
        dev_done   = 1'b0;
        meas_valid = 1'b0;
        if (prog_stb) begin
            g_dev   = prog_result(g_dev, int'(cc_set), gain_dev);
            pend_p  = LAT;
            n_prog  = n_prog + 1;
            last_cc = int'(cc_set);
        end else if (pend_p > 0) begin
            pend_p = pend_p - 1;
            if (pend_p == 0) dev_done = 1'b1;
        end
        if (read_stb) begin
            pend_r = LAT;
        end else if (pend_r > 0) begin
            pend_r = pend_r - 1;
            if (pend_r == 0) begin
                meas_valid = 1'b1;
                meas       = 10'(g_dev);
            end
        end
        if (rst_stb) begin
            g_dev    = 0;
            gain_dev = (gain_dev > 1) ? gain_dev - 1 : 1;
            pend_x   = LAT;
            n_rst    = n_rst + 1;
        end else if (pend_x > 0) begin
            pend_x = pend_x - 1;
            if (pend_x == 0) dev_done = 1'b1;
        end
        if (done) n_done = n_done + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected outcome derived from the requirements and the cell model.
    task automatic ref_run(input int tgt, input int gain0, output bit r_pass,
                           output int r_iters, output int r_progs,
                           output int r_resets, output int r_cc);
        int g, gain, cc, it, rs, err, step;
        g = 0; gain = gain0; cc = INIT; it = 0; rs = 0;
        r_pass = 0; r_iters = 0; r_progs = 0; r_resets = 0; r_cc = cc;
        for (int n = 0; n < 200; n++) begin
            r_progs++;
            r_cc = cc;
            g = prog_result(g, cc, gain);
            err = tgt - g;
            if (err <= TOLB && err >= -TOLB) begin
                r_pass = 1; r_iters = it + 1; break;
            end
            if (err < -TOLB) begin
                if (rs == MAXR) begin r_iters = it + 1; break; end
                rs++; r_resets++; g = 0;
                gain = (gain > 1) ? gain - 1 : 1;
                cc = INIT; it = 0;
                continue;
            end
            if (it + 1 >= CAP) begin r_iters = CAP; break; end
            step = (it < SWI) ? err / 2 : err / 4;
            if (step == 0) step = 1;
            cc = cc + step;
            if (cc > 1023) cc = 1023;
            it++;
        end
    endtask

    task automatic run_case(input int tgt, input int gain, input bit inject, input string tag);
        bit e_pass;
        int e_iters, e_progs, e_resets, e_cc;
        bit finished;
        ref_run(tgt, gain, e_pass, e_iters, e_progs, e_resets, e_cc);
        @(negedge clk); #1;
        g_dev = 0; gain_dev = gain;
        n_prog = 0; n_rst = 0; n_done = 0; last_cc = 0;
        target = 10'(tgt); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (inject) begin
            repeat (5) @(negedge clk);
            #1;
            target = 10'd120; start = 1'b1;     // R2: must be ignored
            @(negedge clk); #1;
            start = 1'b0;
        end
        finished = 0;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk); #1;
            if (n_done > 0) begin finished = 1; break; end
        end
        repeat (3) @(negedge clk);
        #1;
        check(finished, {tag, " R9 run finished"}, int'(finished), 1);
        check(n_done == 1, {tag, " R9 single done pulse"}, n_done, 1);
        check(!busy, {tag, " R9 idle after done"}, int'(busy), 0);
        check(pass == e_pass, {tag, " R4/R6/R8 pass flag"}, int'(pass), int'(e_pass));
        check(int'(iters) == e_iters, {tag, " R4/R6 iteration count"}, int'(iters), e_iters);
        check(n_prog == e_progs, {tag, " R3 program strobes"}, n_prog, e_progs);
        check(n_rst == e_resets, {tag, " R7 reset strobes"}, n_rst, e_resets);
        check(last_cc == e_cc, {tag, " R5 final compliance"}, last_cc, e_cc);
        if (e_pass)
            check((g_dev - tgt <= TOLB) && (tgt - g_dev <= TOLB),
                  {tag, " R4 cell in window"}, g_dev, tgt);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk); #1;
        check(!busy && !done && !prog_stb && !read_stb && !rst_stb,
              "R1 quiet after reset", int'({busy, done, prog_stb, read_stb, rst_stb}), 0);
        check(!pass && iters == 0, "R1 result cleared", int'(iters), 0);

        run_case(300, 4, 0, "converge");
        run_case(400, 1, 0, "R6 cap");
        run_case(100, 12, 0, "R8 restarts exhausted");
        run_case(300, 9, 0, "R7 restart then pass");
        run_case(250, 4, 1, "R2 start ignored");
        run_case(100, 4, 0, "low target");
        run_case(400, 5, 0, "high target");
        for (int k = 0; k < 24; k++) begin
            int t, gn;
            t  = 100 + int'($urandom % 301);
            gn = 2 + int'($urandom % 11);
            run_case(t, gn, 0, "random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule